// File: doc/BRIEF.md
# Raster Pixel Combiner for a 2D Blitter

This block is the per-pixel arithmetic core of a 2D drawing engine. An upstream fetch unit hands it one pixel at a time over a valid/ready handshake. Each pixel carries a full-colour source value or a single monochrome source bit, the pixel currently in the frame buffer, and the low three bits of its screen column and row. The block looks up a pattern operand, expands a monochrome source to full colour, merges pattern, source and destination through a programmable Boolean function, and decides whether the pixel is written at all. The result leaves with a write strobe and per-byte enables for the downstream memory writer.

The configuration inputs hold the pattern store (an 8x8 one-bit grid and eight colour entries), a pattern mode, two colour pairs (one for the pattern, one for source expansion), the 8-bit Boolean function code, an 8/16-bit depth select, an expansion enable and a transparency enable. They are captured along with each pixel at the moment that pixel is accepted. Every stage can be used on any transfer, independently of the others.

Top module: `blt_raster_pipe`

## Requirements
- R1: Every pixel accepted (`in_valid` and `in_ready` high at a rising edge) produces exactly one output handshake, in acceptance order; while `out_valid` is high and `out_ready` is low, `out_valid`, `out_pix`, `out_we` and `out_be` hold their values.
- R2: Two register stages: with `out_ready` held high, a pixel accepted at rising edge n completes its output handshake at edge n+2.
- R3: Result bit i equals bit k of `cfg_rop`, where k = 4*pattern_i + 2*source_i + destination_i (pattern is the most significant index bit).
- R4: In pattern modes 0 (mono), 1 (dither) and 3 (treated as mono), the pattern bit is `cfg_pat_bits[8*y + x]`; a 1 gives `cfg_pat_fg` and a 0 gives `cfg_pat_bg` as the pattern operand.
- R5: In pattern mode 2 (colour row), the pattern operand is `cfg_pat_row[16*x +: 16]`; `in_y` has no effect.
- R6: With `cfg_expand` high, the source operand is `cfg_src_fg` when `in_mono` is 1 and `cfg_src_bg` when it is 0, and `in_src` has no effect; with it low the source operand is `in_src`.
- R7: With `cfg_transp` and `cfg_expand` both high and `in_mono` 0, the pixel still completes its handshakes but leaves with `out_we` 0; in every other case `out_we` is 1.
- R8: With `cfg_depth8` high, `out_pix[15:8]` is 0 and `out_be` is 2'b01; with it low `out_be` is 2'b11.
- R9: Right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel request valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_src | input | 16 | Full-colour source value |
| in_mono | input | 1 | Monochrome source bit |
| in_dst | input | 16 | Current destination pixel |
| in_x | input | 3 | Low bits of screen column |
| in_y | input | 3 | Low bits of screen row |
| cfg_pat_bits | input | 64 | 8x8 one-bit pattern, bit 8*row+column |
| cfg_pat_row | input | 128 | Eight 16-bit colour pattern entries |
| cfg_pat_mode | input | 2 | 0 mono, 1 dither, 2 colour row, 3 mono |
| cfg_pat_fg | input | 16 | Pattern colour for a set bit |
| cfg_pat_bg | input | 16 | Pattern colour for a clear bit |
| cfg_src_fg | input | 16 | Expansion colour for a set source bit |
| cfg_src_bg | input | 16 | Expansion colour for a clear source bit |
| cfg_rop | input | 8 | Boolean function truth table |
| cfg_depth8 | input | 1 | 1 selects 8 bits per pixel |
| cfg_expand | input | 1 | Use the monochrome source bit |
| cfg_transp | input | 1 | Skip writes of background source pixels |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_pix | output | 16 | Result pixel |
| out_we | output | 1 | Write strobe for this pixel |
| out_be | output | 2 | Byte enables |

## Verification
The Boolean stage is driven with random operands under eight function codes: source copy, pattern copy, source XOR destination, pattern XOR destination, destination keep, all-zero, all-one and a three-input select, so that a swapped index bit or a wrong operand shows up in at least one of them. Pattern lookup is swept over every column and row in the one-bit modes (including the reserved code) and over every column with changing rows in colour-row mode, which separates row/column swaps and any dependence on the row. Expansion, transparency and 8-bit depth each get a phase with mixed set and clear source bits, and a final phase randomises everything while the consumer stalls at random, exercising ordering and hold-under-stall.

// File: rtl/blt_pkg.sv
`timescale 1ns/1ps
package blt_pkg;
    localparam int PIX_W    = 16;
    localparam int BE_W     = PIX_W / 8;
    localparam int PAT_N    = 8;
    localparam int IDX_W    = $clog2(PAT_N);
    localparam int MONO_W   = PAT_N * PAT_N;
    localparam int ROW_W    = PAT_N * PIX_W;
    localparam int ROP_W    = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        PAT_MONO   = 2'd0,
        PAT_DITHER = 2'd1,
        PAT_COLOR  = 2'd2,
        PAT_RSVD   = 2'd3
    } pat_mode_e;

    typedef struct packed {
        pix_t             pat;
        pix_t             src;
        pix_t             dst;
        logic [ROP_W-1:0] rop;
        logic             depth8;
        logic             drop;
    } stage1_t;

    function automatic logic [BE_W-1:0] byte_en(input logic depth8);
        logic [BE_W-1:0] be;
        be = depth8 ? {{(BE_W-1){1'b0}}, 1'b1} : {BE_W{1'b1}};
        return be;
    endfunction

    function automatic pix_t depth_mask(input logic depth8);
        return depth8 ? pix_t'({8{1'b1}}) : {PIX_W{1'b1}};
    endfunction
endpackage

// File: rtl/blt_pat_fetch.sv
`timescale 1ns/1ps
module blt_pat_fetch
    import blt_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [IDX_W-1:0]  x,
    input  logic [IDX_W-1:0]  y,
    input  logic [MONO_W-1:0] bits,
    input  logic [ROW_W-1:0]  row,
    input  pix_t              fg,
    input  pix_t              bg,
    output pix_t              pat
);
    logic bit_sel;

    always_comb begin
        bit_sel = bits[{y, x}];
        unique case (pat_mode_e'(mode))
            PAT_COLOR: pat = row[x*PIX_W +: PIX_W];
            default:   pat = bit_sel ? fg : bg;
        endcase
    end
endmodule

// File: rtl/blt_src_expand.sv
`timescale 1ns/1ps
module blt_src_expand
    import blt_pkg::*;
(
    input  logic expand,
    input  logic transp,
    input  logic mono,
    input  pix_t src,
    input  pix_t fg,
    input  pix_t bg,
    output pix_t opnd,
    output logic drop
);
    always_comb begin
        if (expand) opnd = mono ? fg : bg;
        else        opnd = src;
        drop = expand & transp & ~mono;
    end
endmodule

// File: rtl/blt_rop_unit.sv
`timescale 1ns/1ps
module blt_rop_unit
    import blt_pkg::*;
(
    input  logic [ROP_W-1:0] rop,
    input  pix_t             pat,
    input  pix_t             src,
    input  pix_t             dst,
    output pix_t             res
);
    for (genvar i = 0; i < PIX_W; i++) begin : g_bit
        assign res[i] = rop[{pat[i], src[i], dst[i]}];
    end
endmodule

// File: rtl/blt_raster_pipe.sv
`timescale 1ns/1ps
module blt_raster_pipe
    import blt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_src,
    input  logic              in_mono,
    input  logic [15:0]       in_dst,
    input  logic [2:0]        in_x,
    input  logic [2:0]        in_y,
    input  logic [63:0]       cfg_pat_bits,
    input  logic [127:0]      cfg_pat_row,
    input  logic [1:0]        cfg_pat_mode,
    input  logic [15:0]       cfg_pat_fg,
    input  logic [15:0]       cfg_pat_bg,
    input  logic [15:0]       cfg_src_fg,
    input  logic [15:0]       cfg_src_bg,
    input  logic [7:0]        cfg_rop,
    input  logic              cfg_depth8,
    input  logic              cfg_expand,
    input  logic              cfg_transp,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [15:0]       out_pix,
    output logic              out_we,
    output logic [1:0]        out_be
);
    pix_t    pat_w, src_w, rop_res;
    logic    drop_w;
    stage1_t s1_q, s1_d;
    logic    s1_valid;
    logic    adv1, adv2;

    blt_pat_fetch u_pat (
        .mode (cfg_pat_mode),
        .x    (in_x),
        .y    (in_y),
        .bits (cfg_pat_bits),
        .row  (cfg_pat_row),
        .fg   (cfg_pat_fg),
        .bg   (cfg_pat_bg),
        .pat  (pat_w)
    );

    blt_src_expand u_exp (
        .expand (cfg_expand),
        .transp (cfg_transp),
        .mono   (in_mono),
        .src    (in_src),
        .fg     (cfg_src_fg),
        .bg     (cfg_src_bg),
        .opnd   (src_w),
        .drop   (drop_w)
    );

    blt_rop_unit u_rop (
        .rop (s1_q.rop),
        .pat (s1_q.pat),
        .src (s1_q.src),
        .dst (s1_q.dst),
        .res (rop_res)
    );

    always_comb begin
        s1_d.pat    = pat_w;
        s1_d.src    = src_w;
        s1_d.dst    = in_dst;
        s1_d.rop    = cfg_rop;
        s1_d.depth8 = cfg_depth8;
        s1_d.drop   = drop_w;
    end

    assign adv2     = ~out_valid | out_ready;
    assign adv1     = ~s1_valid | adv2;
    assign in_ready = adv1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_q      <= '0;
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_we    <= 1'b0;
            out_be    <= '0;
        end else begin
            if (adv1) begin
                s1_valid <= in_valid;
                if (in_valid) s1_q <= s1_d;
            end
            if (adv2) begin
                out_valid <= s1_valid;
                if (s1_valid) begin
                    out_pix <= rop_res & depth_mask(s1_q.depth8);
                    out_we  <= ~s1_q.drop;
                    out_be  <= byte_en(s1_q.depth8);
                end
            end
        end
    end

    // R1
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_we) && $stable(out_be));

    // R2
    first_stage_load_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> s1_valid);

    // R2
    second_stage_load_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid && (!out_valid || out_ready) |=> out_valid);

    // R8
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_be == 2'b01 |-> out_pix[15:8] == 8'h00);

    // R8
    be_legal_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_be == 2'b01 || out_be == 2'b11));
endmodule

// File: tb/blt_raster_pipe_bench.sv
`timescale 1ns/1ps
module blt_raster_pipe_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, in_valid, in_ready, in_mono, out_valid, out_ready, out_we;
    logic [15:0] in_src, in_dst, out_pix;
    logic [2:0] in_x, in_y;
    logic [63:0] cfg_pat_bits;
    logic [127:0] cfg_pat_row;
    logic [1:0] cfg_pat_mode, out_be;
    logic [15:0] cfg_pat_fg, cfg_pat_bg, cfg_src_fg, cfg_src_bg;
    logic [7:0] cfg_rop;
    logic cfg_depth8, cfg_expand, cfg_transp;

    blt_raster_pipe u_blt_raster_pipe (.*);

    int errors = 0, checks = 0, cyc = 0;
    logic [15:0] q_pix[$];
    logic q_we[$];
    logic [1:0] q_be[$];
    int q_cyc[$];
    string q_tag[$];
    string tag = "R9";
    bit rnd_ready = 0, lat_chk = 0, last_fire = 0, holding = 0, done = 0;
    logic [15:0] hold_pix;
    int n_in = 0, n_out = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_pix();
        logic [15:0] p, s, r;
        int idx;
        if (cfg_pat_mode == 2'd2) p = cfg_pat_row[16*in_x +: 16];
        else p = cfg_pat_bits[8*in_y + in_x] ? cfg_pat_fg : cfg_pat_bg;
        s = cfg_expand ? (in_mono ? cfg_src_fg : cfg_src_bg) : in_src;
        for (int i = 0; i < 16; i++) begin
            idx = 4*p[i] + 2*s[i] + in_dst[i];
            r[i] = cfg_rop[idx];
        end
        if (cfg_depth8) r[15:8] = 8'h00;
        return r;
    endfunction

    task automatic observe();
        cyc++;
        last_fire = in_valid && in_ready;
        if (holding) begin
            check(out_valid === 1'b1 && out_pix === hold_pix, "R1", "stall hold", out_pix, hold_pix);
            holding = 0;
        end
        if (last_fire) begin
            n_in++;
            q_pix.push_back(model_pix());
            q_we.push_back(!(cfg_transp && cfg_expand && !in_mono));
            q_be.push_back(cfg_depth8 ? 2'b01 : 2'b11);
            q_cyc.push_back(cyc);
            q_tag.push_back(tag);
        end
        if (out_valid && out_ready) begin
            n_out++;
            if (q_pix.size() == 0) check(0, "R1", "unexpected output", out_pix, 0);
            else begin
                logic [15:0] ep; logic ew; logic [1:0] eb; int ec; string et;
                ep = q_pix.pop_front(); ew = q_we.pop_front(); eb = q_be.pop_front();
                ec = q_cyc.pop_front(); et = q_tag.pop_front();
                check(out_pix === ep, et, "pixel", out_pix, ep);
                check(out_we === ew, "R7", "write enable", out_we, ew);
                check(out_be === eb, "R8", "byte enables", out_be, eb);
                if (lat_chk) check(cyc - ec == 2, "R2", "latency", cyc - ec, 2);
            end
        end else if (out_valid && !out_ready) begin
            holding = 1;
            hold_pix = out_pix;
        end
    endtask

    task automatic step();
        if (rnd_ready) out_ready = ($urandom % 3) != 0;
        #1;
        observe();
        @(negedge clk);
    endtask

    task automatic send(input logic [15:0] s, input logic m, input logic [15:0] d,
                        input logic [2:0] x, input logic [2:0] y);
        in_valid = 1; in_src = s; in_mono = m; in_dst = d; in_x = x; in_y = y;
        do step(); while (!last_fire);
        in_valid = 0;
    endtask

    task automatic drain();
        for (int k = 0; k < 50 && (q_pix.size() != 0); k++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rops [8] = '{8'hCC, 8'hF0, 8'h66, 8'h5A, 8'hAA, 8'h00, 8'hFF, 8'hB8};
        rst = 1; in_valid = 0; out_ready = 1; in_src = 0; in_mono = 0; in_dst = 0;
        in_x = 0; in_y = 0; cfg_pat_bits = {$urandom, $urandom};
        cfg_pat_row = {$urandom, $urandom, $urandom, $urandom};
        cfg_pat_mode = 0; cfg_pat_fg = 16'hF00D; cfg_pat_bg = 16'h0BAD;
        cfg_src_fg = 16'hC0DE; cfg_src_bg = 16'h1234; cfg_rop = 8'hCC;
        cfg_depth8 = 0; cfg_expand = 0; cfg_transp = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R9
        check(out_valid === 1'b0, "R9", "out_valid after reset", out_valid, 0);
        check(in_ready === 1'b1, "R9", "in_ready after reset", in_ready, 1);
        @(negedge clk);

        // R3 and R2: function codes, back to back, consumer always ready
        lat_chk = 1; tag = "R3";
        foreach (rops[r]) begin
            cfg_rop = rops[r];
            for (int k = 0; k < 6; k++)
                send($urandom, $urandom, $urandom, $urandom, $urandom);
        end
        drain();

        // R4: one-bit pattern modes incl. reserved code
        tag = "R4"; cfg_rop = 8'hF0;
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            cfg_pat_mode = m[1:0];
            for (int yy = 0; yy < 8; yy++)
                for (int xx = 0; xx < 8; xx++)
                    send($urandom, 0, $urandom, xx[2:0], yy[2:0]);
        end
        drain();

        // R5: colour row, row index varied
        tag = "R5"; cfg_pat_mode = 2;
        for (int xx = 0; xx < 8; xx++)
            for (int yy = 0; yy < 3; yy++)
                send($urandom, 0, $urandom, xx[2:0], yy[2:0]);
        drain();

        // R6: expansion, source copy and source XOR pattern
        tag = "R6"; cfg_pat_mode = 0; cfg_expand = 1;
        for (int k = 0; k < 16; k++) begin
            cfg_rop = k[0] ? 8'hCC : 8'h3C;
            send($urandom, k[1], $urandom, $urandom, $urandom);
        end
        drain();

        // R7: transparency
        tag = "R7"; cfg_transp = 1; cfg_rop = 8'hCC;
        for (int k = 0; k < 12; k++) send($urandom, k[0], $urandom, $urandom, $urandom);
        cfg_expand = 0;
        for (int k = 0; k < 4; k++) send($urandom, 0, $urandom, $urandom, $urandom);
        cfg_transp = 0;
        drain();

        // R8: 8-bit depth
        tag = "R8"; cfg_depth8 = 1; cfg_rop = 8'h66;
        for (int k = 0; k < 12; k++) send($urandom, $urandom, $urandom, $urandom, $urandom);
        cfg_depth8 = 0;
        drain();

        // R1: random stalls, everything randomised
        tag = "R1"; lat_chk = 0; rnd_ready = 1;
        for (int k = 0; k < 300; k++) begin
            cfg_rop = $urandom; cfg_pat_mode = $urandom; cfg_depth8 = $urandom;
            cfg_expand = $urandom; cfg_transp = $urandom;
            send($urandom, $urandom, $urandom, $urandom, $urandom);
            if ($urandom % 4 == 0) step();
        end
        rnd_ready = 0; out_ready = 1;
        drain();
        step();
        check(n_in == n_out, "R1", "pixel count", n_out, n_in);
        check(q_pix.size() == 0, "R1", "pending results", q_pix.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule